// File: doc/BRIEF.md
# Bus-Commanded Configuration Load Controller

This block sits between a crate-style host bus and the configuration port of a reprogrammable logic device. The host issues commands as a 5-bit function code and a 4-bit subaddress while the station-select line is high. The block samples the command on the S1 strobe and acts on it in the same clock edge. One function code is always honoured. It arms the controller in programming mode and selects the on-board boot memory as the configuration source. While the controller is armed, the other codes can switch the source to the host bus, raise the device program pulse, push configuration bytes toward the device, or test the device's READY, DONE and INIT lines.

The bus Q response is registered at each S1 and held until the next S1. An accepted command returns Q=1. A status test returns the level of the line it tests. Configuration bytes leave through a one-entry valid/ready stage. `cfg_valid` stays high and `cfg_data` stays stable until the device takes the byte with `cfg_ready`. The bus itself cannot stall, so a byte write that arrives while the stage is still full is refused and returns Q=0. Sending the arm code and then the pulse code starts a reload from boot memory. A full configuration from the host is a long run of byte writes, roughly twelve thousand of them.

Top module: `cfg_load_ctrl`

## Requirements
- R1: After reset, prog_mode, src_host, prog_pulse, cfg_valid and q_resp are all 0.
- R2: Function code 30 with station select, at any subaddress 0 to 15, sets prog_mode=1 and src_host=0 (boot memory) and returns Q=1 after that S1.
- R3: While prog_mode=0, every function code other than 30 leaves all state unchanged and returns Q=0.
- R4: While armed, function code 28 sets src_host=1 and returns Q=1.
- R5: While armed, function code 25 sets prog_pulse=1 and returns Q=1. prog_pulse holds until the next S1, whatever that S1 carries, and that S1 clears it.
- R6: While armed, with no byte pending and prog_pulse=0, function code 16 captures wr_data[7:0] and returns Q=1. cfg_valid then stays 1 with cfg_data stable until a cycle with cfg_ready=1. A code-16 write that arrives while a byte is pending returns Q=0 and does not change cfg_data.
- R7: While prog_pulse=1, cfg_valid is 0 and a code-16 write is refused with Q=0. A byte that was pending reappears on cfg_valid after the pulse ends.
- R8: While armed, function codes 12, 13 and 14 return Q equal to dev_ready, dev_done and dev_init respectively.
- R9: While armed, function code 9 clears prog_mode and returns Q=1. Code 30 still re-arms the block afterwards.
- R10: An S2 strobe with bus_clear or bus_init high clears prog_mode. An S2 strobe without either leaves prog_mode unchanged.
- R11: An S1 with stn_sel low has no effect on state and sets Q=0.
- R12: Function code 30 issued while armed with src_host=1 returns the source to boot memory (src_host=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stn_sel | input | 1 | Station select for the current command |
| s1_strobe | input | 1 | One-cycle command sample strobe |
| s2_strobe | input | 1 | One-cycle strobe that qualifies clear and initialize |
| bus_clear | input | 1 | Bus clear line |
| bus_init | input | 1 | Bus initialize line |
| func_code | input | 5 | Command function code |
| sub_addr | input | 4 | Command subaddress |
| wr_data | input | 8 | Host write data (low byte) |
| dev_ready | input | 1 | Device READY status |
| dev_done | input | 1 | Device DONE status |
| dev_init | input | 1 | Device INIT status |
| q_resp | output | 1 | Registered Q response of the last S1 |
| prog_mode | output | 1 | Programming mode armed |
| src_host | output | 1 | 1 = host bus source, 0 = boot memory |
| prog_pulse | output | 1 | Device program pulse |
| cfg_valid | output | 1 | Configuration byte valid |
| cfg_ready | input | 1 | Device accepts the byte |
| cfg_data | output | 8 | Configuration byte |

## Verification
The bench builds the block with its default widths: a 5-bit function code, 16 subaddresses and an 8-bit byte path. These are small enough to sweep all 32 function codes in the disarmed state, every subaddress for the arm code, all eight status combinations under each test code, and all 256 byte values through the valid/ready stage. The orderings between the program pulse, a pending byte and back-pressure are driven directly, as are the clear and initialize paths.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int FUNC_W = 5;

  localparam logic [FUNC_W-1:0] FC_DISARM  = 5'd9;
  localparam logic [FUNC_W-1:0] FC_T_READY = 5'd12;
  localparam logic [FUNC_W-1:0] FC_T_DONE  = 5'd13;
  localparam logic [FUNC_W-1:0] FC_T_INIT  = 5'd14;
  localparam logic [FUNC_W-1:0] FC_WRBYTE  = 5'd16;
  localparam logic [FUNC_W-1:0] FC_PULSE   = 5'd25;
  localparam logic [FUNC_W-1:0] FC_HOSTSRC = 5'd28;
  localparam logic [FUNC_W-1:0] FC_ARM     = 5'd30;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic pulse;
    logic host;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/cfgld_decode.sv
module cfgld_decode
  import cfgld_pkg::*;
#(
  parameter int SUB_W     = 4,
  parameter int ADDR_SPAN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              s1,
  input  logic [FUNC_W-1:0] func,
  input  logic [SUB_W-1:0]  sub,
  input  logic              armed,
  input  logic              prog,
  input  logic              pend,
  input  logic              st_ready,
  input  logic              st_done,
  input  logic              st_init,
  output cmd_t              cmd,
  output logic              q
);
  logic sub_ok;
  logic hit;
  logic resp;

  assign sub_ok = (int'(sub) < ADDR_SPAN);
  assign hit    = s1 & sel & sub_ok;

  always_comb begin
    resp = 1'b0;
    cmd  = '0;
    if (func == FC_ARM) begin
      resp    = 1'b1;
      cmd.arm = hit;
    end else if (armed) begin
      unique case (func)
        FC_DISARM: begin
          resp       = 1'b1;
          cmd.disarm = hit;
        end
        FC_PULSE: begin
          resp      = 1'b1;
          cmd.pulse = hit;
        end
        FC_HOSTSRC: begin
          resp     = 1'b1;
          cmd.host = hit;
        end
        FC_WRBYTE: begin
          resp   = !prog && !pend;
          cmd.wr = hit && !prog && !pend;
        end
        FC_T_READY: resp = st_ready;
        FC_T_DONE:  resp = st_done;
        FC_T_INIT:  resp = st_init;
        default:    resp = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (s1) q <= hit ? resp : 1'b0;
  end

  p_q_needs_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s1 && !sel) |=> !q);
  p_q_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1 |=> $stable(q));
  p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));
endmodule

// File: rtl/cfgld_mode_regs.sv
module cfgld_mode_regs
  import cfgld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s1,
  input  logic s2,
  input  logic clr,
  input  logic init,
  input  cmd_t cmd,
  output logic armed,
  output logic src_host,
  output logic prog
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      src_host <= 1'b0;
      prog     <= 1'b0;
    end else begin
      if (s2 && (clr || init)) armed <= 1'b0;
      else if (cmd.arm)        armed <= 1'b1;
      else if (cmd.disarm)     armed <= 1'b0;

      if (cmd.arm)       src_host <= 1'b0;
      else if (cmd.host) src_host <= 1'b1;

      if (s1) prog <= cmd.pulse;
    end
  end

  p_pulse_until_s1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s1 |=> $stable(prog));
  p_src_only_at_s1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !s1 |=> $stable(src_host));
  p_clear_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 && (clr || init)) |=> !armed);
endmodule

// File: rtl/cfgld_byte_stage.sv
module cfgld_byte_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              hold_off,
  input  logic              ready,
  output logic              pend,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dout <= '0;
    end else if (load) begin
      pend <= 1'b1;
      dout <= din;
    end else if (valid && ready) begin
      pend <= 1'b0;
    end
  end

  assign valid = pend && !hold_off;

  p_byte_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(valid && ready)) |=> (pend && $stable(dout)));
  p_no_strobe_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> !valid);
  p_no_load_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !load);
endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfgld_pkg::*;
#(
  parameter int SUB_W     = 4,
  parameter int ADDR_SPAN = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stn_sel,
  input  logic              s1_strobe,
  input  logic              s2_strobe,
  input  logic              bus_clear,
  input  logic              bus_init,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [SUB_W-1:0]  sub_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dev_ready,
  input  logic              dev_done,
  input  logic              dev_init,
  output logic              q_resp,
  output logic              prog_mode,
  output logic              src_host,
  output logic              prog_pulse,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DATA_W-1:0] cfg_data
);
  cmd_t cmd;
  logic pend;

  cfgld_decode #(.SUB_W(SUB_W), .ADDR_SPAN(ADDR_SPAN)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(stn_sel), .s1(s1_strobe),
    .func(func_code), .sub(sub_addr), .armed(prog_mode),
    .prog(prog_pulse), .pend(pend), .st_ready(dev_ready),
    .st_done(dev_done), .st_init(dev_init), .cmd(cmd), .q(q_resp)
  );

  cfgld_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n), .s1(s1_strobe), .s2(s2_strobe),
    .clr(bus_clear), .init(bus_init), .cmd(cmd),
    .armed(prog_mode), .src_host(src_host), .prog(prog_pulse)
  );

  cfgld_byte_stage #(.DATA_W(DATA_W)) u_byte (
    .clk(clk), .rst_n(rst_n), .load(cmd.wr), .din(wr_data),
    .hold_off(prog_pulse), .ready(cfg_ready), .pend(pend),
    .valid(cfg_valid), .dout(cfg_data)
  );

  p_idle_when_disarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_strobe && !prog_mode && func_code != FC_ARM) |=> (!q_resp && $stable(src_host)));
  p_arm_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_strobe && stn_sel && func_code == FC_ARM && !(s2_strobe && (bus_clear || bus_init)))
      |=> (prog_mode && !src_host && q_resp));
endmodule

// File: tb/test_cfg_load_ctrl.sv
`timescale 1ns/1ps
module test_cfg_load_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stn_sel = 1'b0, s1_strobe = 1'b0, s2_strobe = 1'b0;
  logic bus_clear = 1'b0, bus_init = 1'b0;
  logic [4:0] func_code = '0;
  logic [3:0] sub_addr = '0;
  logic [7:0] wr_data = '0;
  logic dev_ready = 1'b0, dev_done = 1'b0, dev_init = 1'b0;
  logic q_resp, prog_mode, src_host, prog_pulse, cfg_valid;
  logic cfg_ready = 1'b0;
  logic [7:0] cfg_data;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_load_ctrl i_cfg_load_ctrl (
    .clk(clk), .rst_n(rst_n), .stn_sel(stn_sel), .s1_strobe(s1_strobe),
    .s2_strobe(s2_strobe), .bus_clear(bus_clear), .bus_init(bus_init),
    .func_code(func_code), .sub_addr(sub_addr), .wr_data(wr_data),
    .dev_ready(dev_ready), .dev_done(dev_done), .dev_init(dev_init),
    .q_resp(q_resp), .prog_mode(prog_mode), .src_host(src_host),
    .prog_pulse(prog_pulse), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one S1 cycle; returns at the following negedge, after the edge that sampled it
  task automatic cmd(input logic sel, input int f, input int a, input int d);
    @(negedge clk);
    stn_sel = sel; func_code = 5'(f); sub_addr = 4'(a); wr_data = 8'(d);
    s1_strobe = 1'b1;
    @(negedge clk);
    s1_strobe = 1'b0; stn_sel = 1'b0;
  endtask

  task automatic strobe2(input logic c, input logic z);
    @(negedge clk);
    bus_clear = c; bus_init = z; s2_strobe = 1'b1;
    @(negedge clk);
    s2_strobe = 1'b0; bus_clear = 1'b0; bus_init = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 prog_mode", prog_mode, 0);
    chk("R1 src_host", src_host, 0);
    chk("R1 prog_pulse", prog_pulse, 0);
    chk("R1 cfg_valid", cfg_valid, 0);
    chk("R1 q_resp", q_resp, 0);

    // R3 disarmed sweep of every code but 30, status lines all high
    dev_ready = 1; dev_done = 1; dev_init = 1;
    for (int f = 0; f < 32; f++) begin
      if (f == 30) continue;
      cmd(1, f, f % 16, f);
      chk("R3 q", q_resp, 0);
      chk("R3 mode", prog_mode, 0);
      chk("R3 src", src_host, 0);
      chk("R3 pulse", prog_pulse, 0);
      chk("R3 valid", cfg_valid, 0);
    end

    // R2 arm at every subaddress, R9 disarm with code 9 in between
    for (int a = 0; a < 16; a++) begin
      cmd(1, 30, a, 0);
      chk("R2 q", q_resp, 1);
      chk("R2 mode", prog_mode, 1);
      chk("R2 src", src_host, 0);
      cmd(1, 9, 15 - a, 0);
      chk("R9 q", q_resp, 1);
      chk("R9 mode", prog_mode, 0);
    end

    // R11 no station select
    cmd(0, 30, 0, 0);
    chk("R11 q", q_resp, 0);
    chk("R11 mode", prog_mode, 0);
    cmd(1, 30, 3, 0);
    cmd(0, 28, 0, 0);
    chk("R11 src", src_host, 0);
    chk("R11 q2", q_resp, 0);

    // R4 host source, R12 re-arm returns boot source
    cmd(1, 28, 7, 0);
    chk("R4 q", q_resp, 1);
    chk("R4 src", src_host, 1);
    cmd(1, 30, 0, 0);
    chk("R12 src", src_host, 0);
    chk("R12 mode", prog_mode, 1);

    // R8 status sweep
    for (int s = 0; s < 8; s++) begin
      dev_ready = s[0]; dev_done = s[1]; dev_init = s[2];
      cmd(1, 12, s, 0); chk("R8 ready", q_resp, s & 1);
      cmd(1, 13, s, 0); chk("R8 done", q_resp, (s >> 1) & 1);
      cmd(1, 14, s, 0); chk("R8 init", q_resp, (s >> 2) & 1);
    end

    // R6 back-pressure
    cfg_ready = 0;
    cmd(1, 16, 0, 8'hA5);
    chk("R6 q", q_resp, 1);
    chk("R6 valid", cfg_valid, 1);
    chk("R6 data", cfg_data, 8'hA5);
    idle(4);
    chk("R6 hold valid", cfg_valid, 1);
    chk("R6 hold data", cfg_data, 8'hA5);
    cmd(1, 16, 0, 8'h3C);
    chk("R6 refuse q", q_resp, 0);
    chk("R6 refuse data", cfg_data, 8'hA5);
    cfg_ready = 1;
    idle(1);
    chk("R6 drained", cfg_valid, 0);

    // R6 sweep all byte values with ready high
    for (int d = 0; d < 256; d++) begin
      cmd(1, 16, d % 16, d);
      chk("R6 sweep q", q_resp, 1);
      chk("R6 sweep valid", cfg_valid, 1);
      chk("R6 sweep data", cfg_data, d);
      idle(1);
      chk("R6 sweep taken", cfg_valid, 0);
    end

    // R5 pulse holds until next S1, R7 write refused during pulse
    cmd(1, 25, 2, 0);
    chk("R5 q", q_resp, 1);
    chk("R5 pulse", prog_pulse, 1);
    idle(5);
    chk("R5 pulse hold", prog_pulse, 1);
    cmd(1, 16, 0, 8'h77);
    chk("R7 refuse q", q_resp, 0);
    chk("R5 pulse cleared", prog_pulse, 0);
    chk("R7 nothing loaded", cfg_valid, 0);
    cmd(1, 25, 0, 0);
    cmd(1, 25, 0, 0);
    chk("R5 re-raised", prog_pulse, 1);
    cmd(0, 0, 0, 0);
    chk("R5 unselected clear", prog_pulse, 0);

    // R7 pending byte suppressed then restored
    cfg_ready = 0;
    cmd(1, 16, 0, 8'h11);
    chk("R7 pre valid", cfg_valid, 1);
    cmd(1, 25, 0, 0);
    chk("R7 suppressed", cfg_valid, 0);
    cfg_ready = 1;
    idle(2);
    chk("R7 not taken", prog_pulse, 1);
    cfg_ready = 0;
    cmd(0, 0, 0, 0);
    chk("R7 restored valid", cfg_valid, 1);
    chk("R7 restored data", cfg_data, 8'h11);
    cfg_ready = 1;
    idle(1);

    // R10 clear / initialize
    strobe2(0, 0);
    chk("R10 plain s2", prog_mode, 1);
    strobe2(1, 0);
    chk("R10 clear", prog_mode, 0);
    cmd(1, 28, 0, 0);
    chk("R10 disarmed after C", q_resp, 0);
    cmd(1, 30, 0, 0);
    strobe2(0, 1);
    chk("R10 init", prog_mode, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule